// File: doc/BRIEF.md
# Serial-Address Flash Programming Controller

This block is the byte-wide programming port of a small on-chip code flash of 2048 bytes. The port has no address bus. An internal location counter is cleared by a rising edge on the programming reset input, and each rising edge on a step input moves it forward by one. A two-bit mode input and a program-enable level select what a strobe on the active-low program input does. The choices are a self-timed byte write, a timed full-array erase, a verify read of the addressed byte, or a read of two fixed identification bytes.

The byte array is held in registers inside the block. A write can only clear bits: the new byte is ANDed into the stored one, so the only way to return a byte to FFh is a full erase. A ready output is low for as long as a write or erase is in progress. While it is low, further strobes and step pulses have no effect.

Top module: `flash_prog_ctl`

## Requirements
- R1: After the system reset (`rstN` low), every location reads FFh in verify mode, the location counter is 000h and `rdy` is high.
- R2: A rising edge on `pgmRst` sets the location counter to 000h at the clock edge where it is sampled. This takes priority over a step edge sampled at the same clock edge.
- R3: While `rdy` is high, each rising edge on `stepIn` adds one to the 11-bit location counter. The counter wraps from 7FFh to 000h.
- R4: With `modeSel`=00 (program), `hvEn`=1 and `pgmRst`=1, a falling edge on `progStrobeN` starts a write of `dataIn` to the current location. `rdy` is low for exactly WRITE_CYCLES cycles. When the write ends, the stored byte becomes the old byte AND `dataIn`.
- R5: While `rdy` is low, falling edges on `progStrobeN` and rising edges on `stepIn` are ignored. No second operation starts and the location counter keeps its value.
- R6: A strobe in program mode with `hvEn`=0 starts no write. `rdy` stays high and the array is unchanged.
- R7: With `pgmRst`=1, `hvEn`=0 and `modeSel`=01 (verify), `dataOut` shows the byte at the current location. When no read mode is active, including any time `hvEn`=1, `dataOut` is FFh.
- R8: With `pgmRst`=1, `hvEn`=0 and `modeSel`=11 (signature), `dataOut` is 1Eh at location 000h, 21h at location 001h and 00h elsewhere.
- R9: With `modeSel`=10 (erase), `hvEn`=1 and `pgmRst`=1, a falling edge on `progStrobeN` makes `rdy` go low. If the strobe is then sampled low at ERASE_HOLD consecutive clock edges, counting the falling-edge sample, every byte becomes FFh and `rdy` returns high. If the strobe is released sooner, `rdy` returns high and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| pgmRst | input | 1 | Programming reset level; its rising edge clears the location counter |
| stepIn | input | 1 | Rising edge advances the location counter |
| modeSel | input | 2 | 00 program, 01 verify, 10 erase, 11 signature |
| hvEn | input | 1 | Program-enable level, required for write and erase |
| progStrobeN | input | 1 | Active-low program strobe |
| dataIn | input | 8 | Byte to be written |
| dataOut | output | 8 | Read data, FFh when no read mode is active |
| rdy | output | 1 | High when idle, low while a write or erase runs |

## Verification
The bench writes the same location twice to check the AND behaviour. A design that overwrote the byte would read 3Ch where 24h is expected. It drives step and strobe pulses during a write: a design that honoured them would move the location or start a second write, and the later readback would show it. It steps the counter through all 2048 locations to reach a byte written at 000h, which catches a counter that saturates or has the wrong width. It also holds an erase strobe one cycle short of the threshold and then exactly at it, which catches an off-by-one in the hold count either way.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [1:0] {
    MODE_PROG   = 2'b00,
    MODE_VERIFY = 2'b01,
    MODE_ERASE  = 2'b10,
    MODE_SIG    = 2'b11
  } progMode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WRITE = 2'b01,
    ST_ERASE = 2'b10
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAddr;
    logic incAddr;
    logic latchWr;
    logic commitWr;
    logic commitErase;
  } dpCtl_t;

endpackage

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int WRITE_CYCLES = 16,
  parameter int ERASE_HOLD   = 1250
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   pgmRst,
  input  logic   stepIn,
  input  logic   [1:0] modeSel,
  input  logic   hvEn,
  input  logic   progStrobeN,
  output dpCtl_t ctl,
  output logic   rdy
);

  localparam int CNT_MAX = (WRITE_CYCLES > ERASE_HOLD) ? WRITE_CYCLES : ERASE_HOLD;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [CNT_W-1:0] ER_LAST = CNT_W'(ERASE_HOLD - 1);

  ctrlState_e state;
  logic [CNT_W-1:0] cnt;
  logic prevRst, prevStep, prevStb;
  logic rstEdge, stepEdge, stbFall, canWrite;
  progMode_e mode;

  assign mode     = progMode_e'(modeSel);
  assign rstEdge  = pgmRst & ~prevRst;
  assign stepEdge = stepIn & ~prevStep;
  assign stbFall  = prevStb & ~progStrobeN;
  assign canWrite = hvEn & pgmRst & (state == ST_IDLE);
  assign rdy      = (state == ST_IDLE);

  always_comb begin
    ctl = '0;
    ctl.clrAddr = rstEdge;
    ctl.incAddr = stepEdge & ~rstEdge & (state == ST_IDLE);
    ctl.latchWr = canWrite & stbFall & (mode == MODE_PROG);
    ctl.commitWr = (state == ST_WRITE) && (cnt == WR_LAST);
    ctl.commitErase = (state == ST_ERASE) && !progStrobeN && (cnt == ER_LAST);
  end

  always_ff @(posedge clk) begin
    prevRst  <= pgmRst;
    prevStep <= stepIn;
    prevStb  <= progStrobeN;
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (canWrite && stbFall && mode == MODE_PROG) begin
            state <= ST_WRITE;
            cnt   <= '0;
          end else if (canWrite && stbFall && mode == MODE_ERASE) begin
            state <= ST_ERASE;
            cnt   <= CNT_W'(1);
          end
        end
        ST_WRITE: begin
          if (cnt == WR_LAST) state <= ST_IDLE;
          else                cnt   <= cnt + 1'b1;
        end
        ST_ERASE: begin
          if (progStrobeN || cnt == ER_LAST) state <= ST_IDLE;
          else                               cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_prog_dp.sv
module flash_prog_dp
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] SIG_BYTE0 = 8'h1E,
  parameter logic [DATA_W-1:0] SIG_BYTE1 = 8'h21
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [1:0]        modeSel,
  input  logic              hvEn,
  input  logic              pgmRst,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addrCnt,
  output logic [DATA_W-1:0] dataOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  logic              readOk;

  always_ff @(posedge clk) begin
    if (!rstN)            addrCnt <= '0;
    else if (ctl.clrAddr) addrCnt <= '0;
    else if (ctl.incAddr) addrCnt <= addrCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ctl.latchWr) begin
      wrAddr <= addrCnt;
      wrData <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.commitErase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (ctl.commitWr) begin
      mem[wrAddr] <= mem[wrAddr] & wrData;
    end
  end

  assign readOk = pgmRst & ~hvEn;

  always_comb begin
    dataOut = '1;
    if (readOk && progMode_e'(modeSel) == MODE_VERIFY) begin
      dataOut = mem[addrCnt];
    end else if (readOk && progMode_e'(modeSel) == MODE_SIG) begin
      if (addrCnt == ADDR_W'(0))      dataOut = SIG_BYTE0;
      else if (addrCnt == ADDR_W'(1)) dataOut = SIG_BYTE1;
      else                            dataOut = '0;
    end
  end

endmodule

// File: rtl/flash_prog_ctl.sv
module flash_prog_ctl
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 16,
  parameter int ERASE_HOLD   = 1250
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pgmRst,
  input  logic              stepIn,
  input  logic [1:0]        modeSel,
  input  logic              hvEn,
  input  logic              progStrobeN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              rdy
);

  dpCtl_t            ctl;
  logic [ADDR_W-1:0] addrCnt;

  flash_prog_ctrl #(
    .WRITE_CYCLES(WRITE_CYCLES),
    .ERASE_HOLD  (ERASE_HOLD)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pgmRst     (pgmRst),
    .stepIn     (stepIn),
    .modeSel    (modeSel),
    .hvEn       (hvEn),
    .progStrobeN(progStrobeN),
    .ctl        (ctl),
    .rdy        (rdy)
  );

  flash_prog_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .modeSel(modeSel),
    .hvEn   (hvEn),
    .pgmRst (pgmRst),
    .dataIn (dataIn),
    .addrCnt(addrCnt),
    .dataOut(dataOut)
  );

endmodule

// File: rtl/flash_prog_ctl_chk.sv
module flash_prog_ctl_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              pgmRst,
  input logic              stepIn,
  input logic [1:0]        modeSel,
  input logic              hvEn,
  input logic              progStrobeN,
  input logic [DATA_W-1:0] dataOut,
  input logic              rdy,
  input logic [ADDR_W-1:0] addrCnt
);

  // R4
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdy && !$fell(progStrobeN) |=> rdy);

  // R2
  addr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgmRst) |=> addrCnt == '0);

  // R5
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdy && !$rose(pgmRst) |=> $stable(addrCnt));

  // R3
  step_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdy && $rose(stepIn) && !$rose(pgmRst) |=> addrCnt == ADDR_W'($past(addrCnt) + 1'b1));

  // R7
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pgmRst && !hvEn && modeSel[0]) |-> dataOut == '1);

  // R8
  sig_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgmRst && !hvEn && modeSel == 2'b11 && addrCnt == '0 |-> dataOut == 8'h1E);

endmodule

bind flash_prog_ctl flash_prog_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .pgmRst(pgmRst), .stepIn(stepIn), .modeSel(modeSel),
  .hvEn(hvEn), .progStrobeN(progStrobeN), .dataOut(dataOut), .rdy(rdy),
  .addrCnt(addrCnt)
);

// File: tb/test_flash_prog_ctl.sv
module test_flash_prog_ctl;

  localparam int WR_CYC  = 16;
  localparam int ER_HOLD = 1250;
  localparam logic [1:0] OP_VER = 2'd0, OP_PROG = 2'd1, OP_STEP = 2'd2, OP_RST = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] val;
  } vec_t;

  // walk starts at location 000h after reset
  localparam vec_t VECS [13] = '{
    '{OP_VER,  8'hFF},   // R1 erased after reset
    '{OP_PROG, 8'hA5},
    '{OP_VER,  8'hA5},   // R4
    '{OP_PROG, 8'h3C},
    '{OP_VER,  8'h24},   // R4 AND of A5 and 3C
    '{OP_STEP, 8'h00},
    '{OP_VER,  8'hFF},   // R3 next location untouched
    '{OP_PROG, 8'h0F},
    '{OP_VER,  8'h0F},
    '{OP_RST,  8'h00},
    '{OP_VER,  8'h24},   // R2 back at 000h
    '{OP_STEP, 8'h00},
    '{OP_VER,  8'h0F}    // R3
  };

  logic clk = 0, rstN = 0, pgmRst = 0, stepIn = 0, hvEn = 0, progStrobeN = 1;
  logic [1:0] modeSel = 2'b01;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic rdy;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_prog_ctl #(.WRITE_CYCLES(WR_CYC), .ERASE_HOLD(ER_HOLD)) i_flash_prog_ctl (
    .clk(clk), .rstN(rstN), .pgmRst(pgmRst), .stepIn(stepIn), .modeSel(modeSel),
    .hvEn(hvEn), .progStrobeN(progStrobeN), .dataIn(dataIn), .dataOut(dataOut), .rdy(rdy)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stepPulse();
    @(negedge clk) stepIn = 1;
    @(negedge clk) stepIn = 0;
  endtask

  task automatic rstPulse();
    @(negedge clk) pgmRst = 0;
    @(negedge clk) pgmRst = 1;
  endtask

  task automatic verifyRead(input string req, input logic [7:0] exp);
    @(negedge clk) begin modeSel = 2'b01; hvEn = 0; end
    #1 check(req, dataOut, exp);
  endtask

  task automatic progByte(input logic [7:0] d);
    int busy = 0;
    @(negedge clk) begin modeSel = 2'b00; hvEn = 1; dataIn = d; progStrobeN = 0; end
    @(negedge clk) progStrobeN = 1;
    while (!rdy && busy < 100) begin busy++; @(negedge clk); end
    check("R4 busy cycles", busy, WR_CYC);
    hvEn = 0;
    modeSel = 2'b01;
  endtask

  task automatic eraseHold(input int samples, input string req);
    @(negedge clk) begin modeSel = 2'b10; hvEn = 1; progStrobeN = 0; end
    repeat (samples - 1) @(negedge clk);
    check({req, " busy while held"}, rdy, 0);
    @(negedge clk) progStrobeN = 1;
    @(negedge clk) check({req, " ready after"}, rdy, 1);
    hvEn = 0;
    modeSel = 2'b01;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    pgmRst = 1;
    @(negedge clk);
    check("R1 rdy after reset", rdy, 1);
    foreach (VECS[i]) begin
      case (VECS[i].op)
        OP_VER:  verifyRead($sformatf("R7 vector %0d", i), VECS[i].val);
        OP_PROG: progByte(VECS[i].val);
        OP_STEP: stepPulse();
        default: rstPulse();
      endcase
    end
    // R7 bus idle when program enable is high
    @(negedge clk) begin modeSel = 2'b01; hvEn = 1; end
    #1 check("R7 idle bus with hvEn", dataOut, 8'hFF);
    hvEn = 0;
    // R8 signature bytes
    rstPulse();
    @(negedge clk) modeSel = 2'b11;
    #1 check("R8 sig 000h", dataOut, 8'h1E);
    stepPulse();
    #1 check("R8 sig 001h", dataOut, 8'h21);
    stepPulse();
    #1 check("R8 sig 002h", dataOut, 8'h00);
    // R5 strobe and step ignored while busy, at location 002h
    @(negedge clk) begin modeSel = 2'b00; hvEn = 1; dataIn = 8'h81; progStrobeN = 0; end
    @(negedge clk) progStrobeN = 1;
    dataIn = 8'h00;
    stepPulse();
    @(negedge clk) progStrobeN = 0;
    @(negedge clk) progStrobeN = 1;
    check("R5 still busy", rdy, 0);
    repeat (WR_CYC) @(negedge clk);
    check("R5 single write ends", rdy, 1);
    @(negedge clk) check("R5 no second write", rdy, 1);
    hvEn = 0;
    verifyRead("R5 location and data kept", 8'h81);
    stepPulse();
    verifyRead("R5 step during busy dropped", 8'hFF);
    // R6 no write without enable, at location 003h
    @(negedge clk) begin modeSel = 2'b00; hvEn = 0; dataIn = 8'h00; progStrobeN = 0; end
    @(negedge clk) begin progStrobeN = 1; check("R6 stays ready", rdy, 1); end
    verifyRead("R6 byte unchanged", 8'hFF);
    // R3 wrap 7FFh -> 000h
    rstPulse();
    for (int k = 0; k < 2047; k++) stepPulse();
    verifyRead("R3 at 7FFh", 8'hFF);
    stepPulse();
    verifyRead("R3 wrapped to 000h", 8'h24);
    // R9 short hold: no erase
    eraseHold(ER_HOLD - 1, "R9 short");
    verifyRead("R9 short hold keeps data", 8'h24);
    // R9 full hold: erase
    eraseHold(ER_HOLD, "R9 full");
    verifyRead("R9 erased 000h", 8'hFF);
    stepPulse();
    stepPulse();
    verifyRead("R9 erased 002h", 8'hFF);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule